// File: doc/BRIEF.md
# Low-Speed USB Packet Receiver

This block sits on the D+/D- pair of a low-speed USB device. It runs from a clock at a fixed multiple of the 1.5 Mb/s bit rate (four times by default), passes both lines through two-flop synchronisers and waits for the idle J state. When it is armed, the first rising edge on D+ starts a packet. The block aligns its sample phase to that edge and checks the eight-bit sync field at bit centres. A sync field that breaks off is rejected as a false start.

After a good sync, each sampled level is NRZI-decoded and stuffed bits are removed. Bits are gathered into bytes, least significant bit first. Each finished byte comes out with a one-cycle strobe. A single-ended zero on the line ends the packet, and the block then pulses an end-of-packet strobe with the byte count. A packet that ends part-way through a byte, or that goes past the buffer size, is reported through an abort strobe. PID, CRC and buffering are handled downstream.

Top module: `lsUsbRx`

## Requirements
- R1: After reset, rxValid, rxEop and rxAbort are low, rxLen is 0, and the receiver waits for the J state (D+ low, D- high) before it can be armed.
- R2: An armed receiver starts on a rising D+ edge. It samples OVS/2 clocks after each detected D+ transition, and every OVS clocks while no transition occurs. The sync field must read D+ = 1,0,1,0,1,0,1,1 in that order.
- R3: If one of the first seven sync samples mismatches, or if any sync sample is SE0, nothing is output and the receiver goes back to waiting for J. A D+ pulse shorter than half a bit is rejected in this way.
- R4: If only the eighth sync sample mismatches (it reads 0), the receiver re-arms at once. The next rising D+ edge starts a new sync search, with no J wait.
- R5: Data bits are NRZI-decoded: a level equal to the previous sampled level is 1, and a changed level is 0. The decoded reference at the start of data is the final sync level, which is 1.
- R6: Bytes are assembled least significant bit first. Each complete byte appears on rxByte together with a one-cycle rxValid pulse.
- R7: A sampled bit that follows six consecutive decoded 1s is discarded as a stuffed bit. The run count includes the trailing decoded 1 of the sync field and carries across byte boundaries.
- R8: An SE0 sample with zero or one pending data bits ends the packet. rxEop pulses for one cycle with rxLen equal to the number of bytes received. The single leftover bit allows for an end-of-packet that arrives one bit late.
- R9: An SE0 sample with two to seven pending bits gives a one-cycle rxAbort pulse and no rxEop.
- R10: Completing byte MAX_BYTES+1 gives rxAbort instead of rxValid for that byte. No rxEop follows for that packet.
- R11: After rxEop or rxAbort, a rising D+ edge that is not preceded by a J state does not start a packet.
- R12: rxValid, rxEop and rxAbort are never high together, and each is high for one cycle at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock (OVS times the bit rate) |
| rstN | input | 1 | Active-low synchronous reset |
| dpIn | input | 1 | D+ line, asynchronous |
| dmIn | input | 1 | D- line, asynchronous |
| rxByte | output | 8 | Last completed data byte |
| rxValid | output | 1 | One-cycle strobe: rxByte holds a new byte |
| rxEop | output | 1 | One-cycle strobe: packet ended normally |
| rxLen | output | LEN_W | Byte count of the current or last packet |
| rxAbort | output | 1 | One-cycle strobe: packet aborted (partial byte or overflow) |

## Verification
The checker assumes that the line changes only on bit boundaries spaced exactly OVS clocks apart, and that D+ and D- are never both high. Under these conditions, strobes come at least a bit time apart, so each one can be checked as a single-cycle pulse. The stimulus holds every line level for exactly four clocks, applies changes away from the sampling edge, and uses SE0 and J only at packet ends. The one exception is a deliberate short glitch that exercises false-start rejection.

// File: rtl/lsRxPkg.sv
package lsRxPkg;
  typedef enum logic [1:0] {
    ST_WAITJ,
    ST_ARMED,
    ST_SYNC,
    ST_DATA
  } rxState_t;

  typedef struct packed {
    logic startData;  // load decode state for the first data bit
    logic takeBit;    // a non-SE0 bit-centre sample in the data phase
  } rxStrobes_t;
endpackage

// File: rtl/lsRxDatapath.sv
module lsRxDatapath
  import lsRxPkg::*;
#(
  parameter int OVS   = 4,
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             dpIn,
  input  logic             dmIn,
  input  rxStrobes_t       strobes,
  output logic             riseEdge,
  output logic             sampleTick,
  output logic             lineSe0,
  output logic             lineJ,
  output logic             dpLevel,
  output logic             stuffBit,
  output logic             byteDone,
  output logic [2:0]       pendingBits,
  output logic [LEN_W-1:0] byteCount,
  output logic [7:0]       dataByte
);
  localparam int PH_W    = (OVS > 2) ? $clog2(OVS) : 1;
  localparam int HALF    = OVS / 2;
  localparam int RUN_MAX = 6;

  logic [1:0] dpPipe, dmPipe;
  logic dpSync, dmSync, dpPrev, lastLevel, lineEdge, newBit;
  logic [PH_W-1:0] phase;
  logic [2:0] onesRun, bitCnt;
  logic [7:0] shiftReg;

  // two-flop synchronisers, one per line
  always_ff @(posedge clk) begin
    if (!rstN) begin
      dpPipe <= 2'b00;
      dmPipe <= 2'b11;
      dpPrev <= 1'b0;
    end else begin
      dpPipe <= {dpPipe[0], dpIn};
      dmPipe <= {dmPipe[0], dmIn};
      dpPrev <= dpSync;
    end
  end

  assign dpSync     = dpPipe[1];
  assign dmSync     = dmPipe[1];
  assign lineEdge   = dpSync ^ dpPrev;
  assign riseEdge   = lineEdge & dpSync;
  assign lineSe0    = !dpSync && !dmSync;
  assign lineJ      = !dpSync && dmSync;
  assign dpLevel    = dpSync;
  assign sampleTick = (phase == PH_W'(HALF)) && !lineEdge;

  // bit phase, re-centred on every D+ transition
  always_ff @(posedge clk) begin
    if (!rstN)                        phase <= '0;
    else if (lineEdge)                phase <= PH_W'(1);
    else if (phase == PH_W'(OVS - 1)) phase <= '0;
    else                              phase <= phase + PH_W'(1);
  end

  assign newBit      = (dpSync == lastLevel);
  assign stuffBit    = (onesRun == 3'(RUN_MAX));
  assign byteDone    = strobes.takeBit && !stuffBit && (bitCnt == 3'd7);
  assign pendingBits = bitCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastLevel <= 1'b1;
      onesRun   <= '0;
      bitCnt    <= '0;
      shiftReg  <= '0;
      byteCount <= '0;
      dataByte  <= '0;
    end else if (strobes.startData) begin
      lastLevel <= 1'b1;
      onesRun   <= 3'd1;
      bitCnt    <= '0;
      shiftReg  <= '0;
      byteCount <= '0;
    end else if (strobes.takeBit) begin
      lastLevel <= dpSync;
      if (stuffBit) begin
        onesRun <= '0;
      end else begin
        shiftReg <= {newBit, shiftReg[7:1]};
        bitCnt   <= bitCnt + 3'd1;
        onesRun  <= newBit ? onesRun + 3'd1 : 3'd0;
        if (bitCnt == 3'd7) begin
          dataByte  <= {newBit, shiftReg[7:1]};
          byteCount <= byteCount + LEN_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/lsRxControl.sv
module lsRxControl
  import lsRxPkg::*;
#(
  parameter int MAX_BYTES = 8,
  parameter int LEN_W     = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             riseEdge,
  input  logic             sampleTick,
  input  logic             lineSe0,
  input  logic             lineJ,
  input  logic             dpLevel,
  input  logic             byteDone,
  input  logic [2:0]       pendingBits,
  input  logic [LEN_W-1:0] byteCount,
  output rxStrobes_t       strobes,
  output logic             rxValid,
  output logic             rxEop,
  output logic             rxAbort
);
  rxState_t state;
  logic [2:0] syncIdx;
  logic syncExp, syncLast, overflow;

  // sync field on D+: 1,0,1,0,1,0,1,1
  assign syncLast = (syncIdx == 3'd7);
  assign syncExp  = syncLast | ~syncIdx[0];
  assign overflow = (byteCount == LEN_W'(MAX_BYTES));

  always_comb begin
    strobes.startData = (state == ST_SYNC) && sampleTick && !lineSe0 &&
                        (dpLevel == syncExp) && syncLast;
    strobes.takeBit   = (state == ST_DATA) && sampleTick && !lineSe0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_WAITJ;
      syncIdx <= '0;
      rxValid <= 1'b0;
      rxEop   <= 1'b0;
      rxAbort <= 1'b0;
    end else begin
      rxValid <= 1'b0;
      rxEop   <= 1'b0;
      rxAbort <= 1'b0;
      unique case (state)
        ST_WAITJ: if (lineJ) state <= ST_ARMED;
        ST_ARMED: if (riseEdge) begin
          state   <= ST_SYNC;
          syncIdx <= '0;
        end
        ST_SYNC: if (sampleTick) begin
          if (lineSe0)                  state <= ST_WAITJ;
          else if (dpLevel != syncExp)  state <= syncLast ? ST_ARMED : ST_WAITJ;
          else if (syncLast)            state <= ST_DATA;
          else                          syncIdx <= syncIdx + 3'd1;
        end
        ST_DATA: begin
          if (sampleTick && lineSe0) begin
            if (pendingBits <= 3'd1) rxEop <= 1'b1;
            else                     rxAbort <= 1'b1;
            state <= ST_WAITJ;
          end else if (byteDone) begin
            if (overflow) begin
              rxAbort <= 1'b1;
              state   <= ST_WAITJ;
            end else begin
              rxValid <= 1'b1;
            end
          end
        end
        default: state <= ST_WAITJ;
      endcase
    end
  end
endmodule

// File: rtl/lsUsbRx.sv
module lsUsbRx
  import lsRxPkg::*;
#(
  parameter int OVS       = 4,
  parameter int MAX_BYTES = 8,
  parameter int LEN_W     = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             dpIn,
  input  logic             dmIn,
  output logic [7:0]       rxByte,
  output logic             rxValid,
  output logic             rxEop,
  output logic [LEN_W-1:0] rxLen,
  output logic             rxAbort
);
  rxStrobes_t strobes;
  logic riseEdge, sampleTick, lineSe0, lineJ, dpLevel, stuffBit, byteDone;
  logic [2:0] pendingBits;

  lsRxDatapath #(.OVS(OVS), .LEN_W(LEN_W)) dpath (
    .clk(clk), .rstN(rstN), .dpIn(dpIn), .dmIn(dmIn), .strobes(strobes),
    .riseEdge(riseEdge), .sampleTick(sampleTick), .lineSe0(lineSe0),
    .lineJ(lineJ), .dpLevel(dpLevel), .stuffBit(stuffBit),
    .byteDone(byteDone), .pendingBits(pendingBits), .byteCount(rxLen),
    .dataByte(rxByte)
  );

  lsRxControl #(.MAX_BYTES(MAX_BYTES), .LEN_W(LEN_W)) ctrl (
    .clk(clk), .rstN(rstN), .riseEdge(riseEdge), .sampleTick(sampleTick),
    .lineSe0(lineSe0), .lineJ(lineJ), .dpLevel(dpLevel),
    .byteDone(byteDone), .pendingBits(pendingBits), .byteCount(rxLen),
    .strobes(strobes), .rxValid(rxValid), .rxEop(rxEop), .rxAbort(rxAbort)
  );

  logic unusedStuff;
  assign unusedStuff = stuffBit;
endmodule

// File: rtl/lsUsbRxChecker.sv
module lsUsbRxChecker #(
  parameter int MAX_BYTES = 8,
  parameter int LEN_W     = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             rxValid,
  input logic             rxEop,
  input logic             rxAbort,
  input logic [LEN_W-1:0] rxLen
);
  a_r12_strobes_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({rxValid, rxEop, rxAbort}));

  a_r6_valid_single: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);

  a_r8_eop_single: assert property (@(posedge clk) disable iff (!rstN)
    rxEop |=> !rxEop);

  a_r8_len_in_range: assert property (@(posedge clk) disable iff (!rstN)
    rxEop |-> (rxLen <= LEN_W'(MAX_BYTES)));

  a_r10_quiet_after_abort: assert property (@(posedge clk) disable iff (!rstN)
    rxAbort |=> (!rxValid && !rxEop && !rxAbort));

  a_r8_len_held_at_eop: assert property (@(posedge clk) disable iff (!rstN)
    rxEop |-> $stable(rxLen));
endmodule

bind lsUsbRx lsUsbRxChecker #(.MAX_BYTES(MAX_BYTES), .LEN_W(LEN_W)) chk (
  .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxEop(rxEop),
  .rxAbort(rxAbort), .rxLen(rxLen)
);

// File: tb/lsUsbRx_test.sv
module lsUsbRx_test;
  localparam int OVS = 4;
  localparam int MAXB = 8;
  localparam int NV = 7;
  localparam int vLen  [NV] = '{3, 2, 4, 8, 9, 2, 1};
  localparam int vMode [NV] = '{0, 0, 1, 0, 0, 2, 0};  // 1: one late bit, 2: three extra bits
  localparam logic [71:0] vData [NV] = '{
    72'h013CA5, 72'hFFFF, 72'hFE7F8000, 72'h8877665544332211,
    72'h090807060504030201, 72'h5AC3, 72'hFE};

  logic clk = 0, rstN = 0, dpIn = 0, dmIn = 1;
  logic [7:0] rxByte;
  logic rxValid, rxEop, rxAbort;
  logic [7:0] rxLen;

  lsUsbRx #(.OVS(OVS), .MAX_BYTES(MAXB), .LEN_W(8)) uut (
    .clk(clk), .rstN(rstN), .dpIn(dpIn), .dmIn(dmIn), .rxByte(rxByte),
    .rxValid(rxValid), .rxEop(rxEop), .rxLen(rxLen), .rxAbort(rxAbort));

  always #5 clk = ~clk;

  int checks = 0, fails = 0, nValid = 0, nEop = 0, nAbort = 0, lastLen = 0;
  logic [7:0] got [16];
  bit curK = 0, finished = 0;
  int ones = 0;

  always @(negedge clk) if (rstN) begin
    if (rxValid) begin if (nValid < 16) got[nValid] = rxByte; nValid++; end
    if (rxEop) begin nEop++; lastLen = int'(rxLen); end
    if (rxAbort) nAbort++;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clearMon(); nValid = 0; nEop = 0; nAbort = 0; lastLen = -1; endtask
  task automatic lvl(input bit d, input bit m);
    @(negedge clk); dpIn = d; dmIn = m;
    repeat (OVS - 1) @(negedge clk);
  endtask
  task automatic putK(input bit k); curK = k; lvl(k, !k); endtask
  task automatic rawBit(input bit b); if (!b) curK = !curK; putK(curK); endtask
  task automatic dataBit(input bit b);
    rawBit(b);
    if (b) ones++; else ones = 0;
    if (ones == 6) begin rawBit(1'b0); ones = 0; end
  endtask
  task automatic idle(input int n); repeat (n) putK(1'b0); endtask
  task automatic syncField(); curK = 0; for (int i = 0; i < 8; i++) rawBit(i == 7); ones = 1; endtask
  task automatic sendBody(input int n, input logic [71:0] d, input int mode);
    syncField();
    for (int i = 0; i < n; i++) for (int b = 0; b < 8; b++) dataBit(d[i*8+b]);
    if (mode == 1) rawBit(1'b0);
    if (mode == 2) repeat (3) rawBit(1'b0);
    lvl(0, 0); lvl(0, 0);
  endtask
  task automatic sendPacket(input int n, input logic [71:0] d, input int mode);
    sendBody(n, d, mode); idle(3);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 rxValid", rxValid, 0);
    check("R1 rxEop", rxEop, 0);
    check("R1 rxAbort", rxAbort, 0);
    check("R1 rxLen", rxLen, 0);
    idle(4);

    // vector table: R2 R5 R6 R7 R8 R9 R10
    for (int v = 0; v < NV; v++) begin
      int expN, expEop;
      clearMon();
      sendPacket(vLen[v], vData[v], vMode[v]);
      expN = (vLen[v] > MAXB) ? MAXB : vLen[v];
      expEop = (vLen[v] <= MAXB && vMode[v] != 2) ? 1 : 0;
      check("R6 byte count", nValid, expN);
      for (int i = 0; i < expN; i++)
        check(v == 1 ? "R7 unstuffed byte" : "R5 R6 byte value", got[i], int'(vData[v][i*8 +: 8]));
      check(vMode[v] == 1 ? "R8 late eop" : "R8 eop", nEop, expEop);
      if (expEop) check("R8 rxLen", lastLen, vLen[v]);
      check(vLen[v] > MAXB ? "R10 overflow abort" : "R9 abort", nAbort, 1 - expEop);
    end

    // R3 short glitch rejected, then a good packet
    clearMon();
    @(negedge clk); dpIn = 1; dmIn = 0;
    @(negedge clk); dpIn = 0; dmIn = 1;
    idle(12);
    check("R3 glitch no output", nValid + nEop + nAbort, 0);
    sendPacket(1, 72'h5A, 0);
    check("R3 recovery eop", nEop, 1);
    check("R3 recovery byte", got[0], 8'h5A);

    // R3 sync mismatch at the fourth sample
    clearMon();
    putK(1); putK(0); putK(1); putK(1); putK(1);
    idle(6);
    check("R3 bad sync no output", nValid + nEop + nAbort, 0);

    // R4 last sync bit reads 0, then immediate resync
    clearMon();
    curK = 0;
    for (int i = 0; i < 7; i++) rawBit(1'b0);
    putK(0);
    sendPacket(2, 72'h6699, 0);
    check("R4 resync eop", nEop, 1);
    check("R4 resync len", lastLen, 2);
    check("R4 resync byte", got[1], 8'h66);

    // R11 no re-arm without J between packets
    clearMon();
    sendBody(1, 72'h42, 0);
    sendPacket(2, 72'hFFFF, 0);
    check("R11 first packet eop", nEop, 1);
    check("R11 first packet bytes", nValid, 1);
    check("R11 second packet ignored", nAbort, 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule